// File: doc/BRIEF.md
# Packed SIMD Integer ALU with Saturation

This unit treats two 64-bit operands as packed vectors of equal-width integer lanes, each 8, 16, 32 or 64 bits wide. In one pass it adds or subtracts lane by lane, and carries never cross the selected lane boundaries. Each lane result either wraps, or clamps to the signed or unsigned range of its lane. The unit also applies bitwise logic across the whole word. It compares lanes for equality or signed greater-than and writes the outcome as a mask that fills the whole lane. Finally, it can interleave the lanes of the low or high halves of the two operands.

A caller presents an operation code, a lane-size code and two operands, and raises `in_valid` for one clock per operation. The result is captured in a register. It appears with `out_valid` on the next clock and stays held until the next accepted operation.

Top module: `simd_alu`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock. `result` loads only on a clock where `in_valid` is high and holds its value otherwise. Reset (active-low `rst_n`) clears both to zero.
- R2: Lane-size code 0/1/2/3 selects lanes of 8/16/32/64 bits, and lane i occupies bits [i*L+L-1 : i*L]. Op 0 adds and op 3 subtracts (A minus B) modulo 2^L in every lane, with no carry or borrow passing into the next lane.
- R3: Op 1 (add) and op 4 (subtract) use signed saturation. A lane whose two's-complement result overflows becomes 2^(L-1)-1 if the true result is positive and -2^(L-1) if it is negative.
- R4: Op 2 (add) and op 5 (subtract) use unsigned saturation. A sum above 2^L-1 becomes all ones, so 16-bit F000h plus 3000h gives FFFFh. A difference below zero becomes zero.
- R5: Op 6 gives A AND B, op 7 gives (NOT A) AND B, op 8 gives A OR B and op 9 gives A XOR B, all bitwise over the full 64 bits. The lane-size code has no effect on these ops.
- R6: Op 10 writes all ones to each lane where the A lane equals the B lane, and all zeros elsewhere.
- R7: Op 11 writes all ones to each lane where the A lane, read as signed two's complement, is greater than the B lane, and all zeros elsewhere.
- R8: Op 12 takes the lanes of bits 31:0 of A and B, and op 13 takes the lanes of bits 63:32. Result lane 2k is the k-th chosen A lane and lane 2k+1 is the k-th chosen B lane. With 64-bit lanes, op 12 returns A and op 13 returns B.
- R9: Op codes 14 and 15 produce a zero result, still with `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| op | input | 4 | Operation code (see R2 to R9) |
| lane_sz | input | 2 | Lane width code: 0=8, 1=16, 2=32, 3=64 bits |
| opa | input | 64 | Operand A |
| opb | input | 64 | Operand B |
| out_valid | output | 1 | Result valid, one clock after `in_valid` |
| result | output | 64 | Registered packed result |

## Verification
The bench builds the unit with its default 64-bit word, so all four lane widths are live. The 64-bit lane case reaches the extreme carry and clamp positions at bit 63. The unpack operations produce both their 32-bit-half interleaves and the whole-operand quadword case. Directed vectors hit each clamp limit, lane-boundary carries and signed compares across the sign bit. Random vectors with gaps in `in_valid` exercise the hold behaviour between operations.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [3:0] {
    OP_ADD_W  = 4'd0,
    OP_ADD_SS = 4'd1,
    OP_ADD_US = 4'd2,
    OP_SUB_W  = 4'd3,
    OP_SUB_SS = 4'd4,
    OP_SUB_US = 4'd5,
    OP_AND    = 4'd6,
    OP_ANDN   = 4'd7,
    OP_OR     = 4'd8,
    OP_XOR    = 4'd9,
    OP_CMPEQ  = 4'd10,
    OP_CMPGT  = 4'd11,
    OP_UNPL   = 4'd12,
    OP_UNPH   = 4'd13,
    OP_RSV0   = 4'd14,
    OP_RSV1   = 4'd15
  } simd_op_e;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_W = 2'd1,
    SZ_D = 2'd2,
    SZ_Q = 2'd3
  } lane_sz_e;

  typedef enum logic [1:0] {
    SAT_WRAP = 2'd0,
    SAT_SGN  = 2'd1,
    SAT_UNS  = 2'd2
  } sat_e;

  localparam int unsigned NUM_SIZES = 4;

  // One lane of add/subtract with optional clamping. Bit 64 of the
  // return value flags that the lane was clamped.
  function automatic logic [64:0] lane_arith(
    input logic [63:0] x,
    input logic [63:0] y,
    input int unsigned lw,
    input logic        sub,
    input sat_e        md
  );
    logic [63:0] m, xm, yy, r, smax;
    logic [64:0] s;
    logic cu, sx, sy, sr, ovs, clamp;
    m    = (lw >= 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << lw) - 64'd1);
    xm   = x & m;
    yy   = (sub ? ~y : y) & m;
    s    = {1'b0, xm} + {1'b0, yy} + {64'd0, sub};
    r    = s[63:0] & m;
    cu   = s[lw];
    sx   = xm[lw-1];
    sy   = yy[lw-1];
    sr   = r[lw-1];
    ovs  = (sx == sy) && (sr != sx);
    smax = m >> 1;
    clamp = 1'b0;
    case (md)
      SAT_SGN: if (ovs) begin
        r = sx ? (~smax & m) : smax;
        clamp = 1'b1;
      end
      SAT_UNS: begin
        if (!sub && cu) begin
          r = m;
          clamp = 1'b1;
        end else if (sub && !cu) begin
          r = 64'd0;
          clamp = 1'b1;
        end
      end
      default: ;
    endcase
    return {clamp, r};
  endfunction
endpackage

// File: rtl/simd_addsub.sv
module simd_addsub
  import simd_pkg::*;
#(
  parameter int unsigned WORD_W = 64
) (
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  lane_sz_e          sz,
  input  logic              is_sub,
  input  sat_e              mode,
  output logic [WORD_W-1:0] res,
  output logic              clamp_hit
);
  logic [WORD_W-1:0] res_k   [NUM_SIZES];
  logic [WORD_W-1:0] clamp_k [NUM_SIZES];

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
    localparam int unsigned LW = 8 << k;
    localparam int unsigned NL = WORD_W / LW;
    for (genvar i = 0; i < NL; i++) begin : g_lane
      logic [64:0] lane_out;
      assign lane_out = lane_arith(64'(a[i*LW +: LW]), 64'(b[i*LW +: LW]),
                                   LW, is_sub, mode);
      assign res_k[k][i*LW +: LW]   = lane_out[LW-1:0];
      assign clamp_k[k][i*LW +: LW] = {LW{lane_out[64]}};
    end
  end

  always_comb begin
    res       = res_k[sz];
    clamp_hit = |clamp_k[sz];
  end
endmodule

// File: rtl/simd_compare.sv
module simd_compare
  import simd_pkg::*;
#(
  parameter int unsigned WORD_W = 64
) (
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  lane_sz_e          sz,
  output logic [WORD_W-1:0] eq_mask,
  output logic [WORD_W-1:0] gt_mask
);
  logic [WORD_W-1:0] eq_k [NUM_SIZES];
  logic [WORD_W-1:0] gt_k [NUM_SIZES];

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
    localparam int unsigned LW = 8 << k;
    localparam int unsigned NL = WORD_W / LW;
    for (genvar i = 0; i < NL; i++) begin : g_lane
      logic [LW-1:0] la, lb;
      logic          hit_eq, hit_gt;
      assign la     = a[i*LW +: LW];
      assign lb     = b[i*LW +: LW];
      assign hit_eq = (la == lb);
      assign hit_gt = ($signed(la) > $signed(lb));
      assign eq_k[k][i*LW +: LW] = {LW{hit_eq}};
      assign gt_k[k][i*LW +: LW] = {LW{hit_gt}};
    end
  end

  always_comb begin
    eq_mask = eq_k[sz];
    gt_mask = gt_k[sz];
  end
endmodule

// File: rtl/simd_unpack.sv
module simd_unpack
  import simd_pkg::*;
#(
  parameter int unsigned WORD_W = 64
) (
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  lane_sz_e          sz,
  output logic [WORD_W-1:0] lo_res,
  output logic [WORD_W-1:0] hi_res
);
  localparam int unsigned HALF_W = WORD_W / 2;
  logic [WORD_W-1:0] lo_k [NUM_SIZES];
  logic [WORD_W-1:0] hi_k [NUM_SIZES];

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
    localparam int unsigned LW = 8 << k;
    if (LW < WORD_W) begin : g_ilv
      localparam int unsigned NH = HALF_W / LW;
      for (genvar i = 0; i < NH; i++) begin : g_pair
        assign lo_k[k][(2*i)*LW   +: LW] = a[i*LW +: LW];
        assign lo_k[k][(2*i+1)*LW +: LW] = b[i*LW +: LW];
        assign hi_k[k][(2*i)*LW   +: LW] = a[HALF_W + i*LW +: LW];
        assign hi_k[k][(2*i+1)*LW +: LW] = b[HALF_W + i*LW +: LW];
      end
    end else begin : g_whole
      assign lo_k[k] = a;
      assign hi_k[k] = b;
    end
  end

  always_comb begin
    lo_res = lo_k[sz];
    hi_res = hi_k[sz];
  end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_pkg::*;
#(
  parameter int unsigned WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        op,
  input  logic [1:0]        lane_sz,
  input  logic [WORD_W-1:0] opa,
  input  logic [WORD_W-1:0] opb,
  output logic              out_valid,
  output logic [WORD_W-1:0] result
);
  simd_op_e op_e;
  lane_sz_e sz_e;
  assign op_e = simd_op_e'(op);
  assign sz_e = lane_sz_e'(lane_sz);

  // Decode of the arithmetic family
  logic is_sub;
  sat_e sat_mode;
  always_comb begin
    is_sub   = 1'b0;
    sat_mode = SAT_WRAP;
    case (op_e)
      OP_ADD_SS: sat_mode = SAT_SGN;
      OP_ADD_US: sat_mode = SAT_UNS;
      OP_SUB_W:  is_sub = 1'b1;
      OP_SUB_SS: begin is_sub = 1'b1; sat_mode = SAT_SGN; end
      OP_SUB_US: begin is_sub = 1'b1; sat_mode = SAT_UNS; end
      default: ;
    endcase
  end

  logic [WORD_W-1:0] arith_res, eq_mask, gt_mask, unp_lo, unp_hi;
  logic              clamp_hit;

  simd_addsub #(.WORD_W(WORD_W)) u_addsub (
    .a(opa), .b(opb), .sz(sz_e), .is_sub(is_sub), .mode(sat_mode),
    .res(arith_res), .clamp_hit(clamp_hit)
  );

  simd_compare #(.WORD_W(WORD_W)) u_cmp (
    .a(opa), .b(opb), .sz(sz_e), .eq_mask(eq_mask), .gt_mask(gt_mask)
  );

  simd_unpack #(.WORD_W(WORD_W)) u_unp (
    .a(opa), .b(opb), .sz(sz_e), .lo_res(unp_lo), .hi_res(unp_hi)
  );

  logic [WORD_W-1:0] next_res;
  always_comb begin
    case (op_e)
      OP_ADD_W, OP_ADD_SS, OP_ADD_US,
      OP_SUB_W, OP_SUB_SS, OP_SUB_US: next_res = arith_res;
      OP_AND:   next_res = opa & opb;
      OP_ANDN:  next_res = ~opa & opb;
      OP_OR:    next_res = opa | opb;
      OP_XOR:   next_res = opa ^ opb;
      OP_CMPEQ: next_res = eq_mask;
      OP_CMPGT: next_res = gt_mask;
      OP_UNPL:  next_res = unp_lo;
      OP_UNPH:  next_res = unp_hi;
      default:  next_res = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_res;
    end
  end

  // R1
  valid_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  // R1
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> $stable(result));

  // R5
  xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && op_e == OP_XOR) |-> result == ($past(opa) ^ $past(opb)));

  // R6
  eq_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && op_e == OP_CMPEQ && opa == opb) |-> &result);

  // R2
  sub_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && op_e == OP_SUB_W && opa == opb) |-> result == '0);

  // R4
  usat_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && op_e == OP_ADD_US && sz_e == SZ_Q && clamp_hit) |-> &result);

  // R3
  ssat_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && op_e == OP_ADD_SS && sz_e == SZ_Q &&
          !opa[WORD_W-1] && !opb[WORD_W-1]) |-> !result[WORD_W-1]);
endmodule

// File: tb/tb_simd_alu.sv
`timescale 1ns/1ps
module tb_simd_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic [1:0]  lane_sz = '0;
  logic [63:0] opa = '0, opb = '0;
  logic        out_valid;
  logic [63:0] result;

  int n_vec = 0;
  int n_bad = 0;
  bit chk_en = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  simd_alu dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .lane_sz(lane_sz),
    .opa(opa), .opb(opb), .out_valid(out_valid), .result(result)
  );

  function automatic string req_of(input logic [3:0] c);
    case (c)
      4'd0, 4'd3: return "R2";
      4'd1, 4'd4: return "R3";
      4'd2, 4'd5: return "R4";
      4'd6, 4'd7, 4'd8, 4'd9: return "R5";
      4'd10: return "R6";
      4'd11: return "R7";
      4'd12, 4'd13: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [63:0] get_lane(input logic [63:0] x, input int i, input int lw);
    logic [63:0] m;
    m = (lw == 64) ? '1 : ((64'd1 << lw) - 1);
    return (x >> (i * lw)) & m;
  endfunction

  // Behavioural reference built from the requirement text
  function automatic logic [63:0] model(input logic [3:0] c, input logic [1:0] s,
                                        input logic [63:0] a, input logic [63:0] b);
    int lw, n;
    logic [63:0] out, m;
    logic signed [66:0] ua, ub, sa, sb, t, hi, lo;
    lw  = 8 << s;
    n   = 64 / lw;
    m   = (lw == 64) ? '1 : ((64'd1 << lw) - 1);
    out = '0;
    case (c)
      4'd6:  return a & b;
      4'd7:  return ~a & b;
      4'd8:  return a | b;
      4'd9:  return a ^ b;
      4'd12, 4'd13: begin
        if (lw == 64) return (c == 4'd12) ? a : b;
        for (int k = 0; k < 32 / lw; k++) begin
          int base;
          base = (c == 4'd12) ? 0 : 32 / lw;
          out |= get_lane(a, base + k, lw) << ((2 * k) * lw);
          out |= get_lane(b, base + k, lw) << ((2 * k + 1) * lw);
        end
        return out;
      end
      4'd14, 4'd15: return '0;
      default: ;
    endcase
    for (int i = 0; i < n; i++) begin
      logic [63:0] la, lb, lr;
      la = get_lane(a, i, lw);
      lb = get_lane(b, i, lw);
      ua = $signed({3'b000, la});
      ub = $signed({3'b000, lb});
      sa = la[lw-1] ? ua - (67'sd1 <<< lw) : ua;
      sb = lb[lw-1] ? ub - (67'sd1 <<< lw) : ub;
      lr = '0;
      case (c)
        4'd0: begin t = ua + ub; lr = t[63:0] & m; end
        4'd3: begin t = ua - ub; lr = t[63:0] & m; end
        4'd1, 4'd4: begin
          t  = (c == 4'd1) ? sa + sb : sa - sb;
          hi = (67'sd1 <<< (lw - 1)) - 67'sd1;
          lo = -(67'sd1 <<< (lw - 1));
          if (t > hi) t = hi;
          if (t < lo) t = lo;
          lr = t[63:0] & m;
        end
        4'd2, 4'd5: begin
          t = (c == 4'd2) ? ua + ub : ua - ub;
          if (t > $signed({3'b000, m})) t = $signed({3'b000, m});
          if (t < 0) t = 0;
          lr = t[63:0];
        end
        4'd10: lr = (la == lb) ? m : '0;
        4'd11: lr = (sa > sb) ? m : '0;
        default: ;
      endcase
      out |= lr << (i * lw);
    end
    return out;
  endfunction

  // Cycle model of the output register
  logic        m_valid;
  logic [63:0] m_res;
  logic [3:0]  m_op;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_res   <= '0;
      m_op    <= '0;
    end else begin
      m_valid <= in_valid;
      if (in_valid) begin
        m_res <= model(op, lane_sz, opa, opb);
        m_op  <= op;
      end
    end
  end

  // Compare on every clock, away from the rising edge
  always @(negedge clk) begin
    if (chk_en) begin
      n_vec++;
      if (out_valid !== m_valid) begin
        n_bad++;
        $display("FAIL R1 out_valid actual=%0b expected=%0b", out_valid, m_valid);
      end
      if (result !== m_res) begin
        n_bad++;
        if (m_valid)
          $display("FAIL %s op=%0d result actual=%h expected=%h", req_of(m_op), m_op, result, m_res);
        else
          $display("FAIL R1 held result actual=%h expected=%h", result, m_res);
      end
    end
  end

  task automatic apply(input logic [3:0] c, input logic [1:0] s,
                       input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    in_valid = 1'b1; op = c; lane_sz = s; opa = a; opb = b;
  endtask

  task automatic idle(input int cycles);
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      opa = {$urandom, $urandom}; opb = {$urandom, $urandom};
      op = 4'($urandom); lane_sz = 2'($urandom);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    n_vec++;
    if (out_valid !== 1'b0 || result !== 64'd0) begin
      n_bad++;
      $display("FAIL R1 reset actual=%0b/%h expected=0/0", out_valid, result);
    end
    rst_n = 1'b1;
    chk_en = 1'b1;
    // R4: 16-bit unsigned clamp example, and underflow to zero
    apply(4'd2, 2'd1, 64'h0000_0000_0000_F000, 64'h0000_0000_0000_3000);
    apply(4'd5, 2'd0, 64'h0102_0304_0506_0708, 64'h0201_0403_0605_0807);
    apply(4'd2, 2'd3, 64'hFFFF_FFFF_FFFF_FFF0, 64'h20);
    // R2: wrap with carries cut at lane edges
    apply(4'd0, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101);
    apply(4'd0, 2'd1, 64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001);
    apply(4'd3, 2'd2, 64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001);
    apply(4'd0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
    // R3: signed clamps in both directions
    apply(4'd1, 2'd1, 64'h7FFF_8000_7FFF_0001, 64'h0001_FFFF_0000_0001);
    apply(4'd4, 2'd0, 64'h8080_7F7F_0000_0000, 64'h0101_FFFF_0000_0000);
    apply(4'd1, 2'd3, 64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF);
    apply(4'd4, 2'd2, 64'h8000_0000_7FFF_FFFF, 64'h0000_0001_FFFF_FFFF);
    // R5: logic ops, lane size irrelevant
    apply(4'd6, 2'd0, 64'hA5A5_A5A5_A5A5_A5A5, 64'hF0F0_F0F0_F0F0_F0F0);
    apply(4'd7, 2'd3, 64'hFF00_FF00_FF00_FF00, 64'h0FF0_0FF0_0FF0_0FF0);
    apply(4'd8, 2'd1, 64'h1234_0000_0000_5678, 64'h0000_9ABC_DEF0_0000);
    apply(4'd9, 2'd2, 64'hA5A5_A5A5_A5A5_A5A5, 64'hFFFF_FFFF_FFFF_FFFF);
    // R6, R7: lane masks, signed compare across the sign bit
    apply(4'd10, 2'd0, 64'h1122_3344_5566_7788, 64'h1100_3300_5500_7700);
    apply(4'd11, 2'd0, 64'h7F80_0001_FF00_0000, 64'h8001_FF00_0000_0000);
    apply(4'd11, 2'd1, 64'h8000_7FFF_0000_FFFF, 64'h7FFF_8000_FFFF_0000);
    apply(4'd11, 2'd3, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF);
    // R8: unpack low and high, every lane size
    for (int s = 0; s < 4; s++) begin
      apply(4'd12, 2'(s), 64'h8877_6655_4433_2211, 64'hFFEE_DDCC_BBAA_0099);
      apply(4'd13, 2'(s), 64'h8877_6655_4433_2211, 64'hFFEE_DDCC_BBAA_0099);
    end
    // R9: reserved codes
    apply(4'd14, 2'd0, 64'h1234, 64'h5678);
    apply(4'd15, 2'd3, 64'hFFFF, 64'hFFFF);
    // R1: hold while idle
    idle(4);
    // Random mix with gaps
    for (int k = 0; k < 4000; k++) begin
      logic [63:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = ($urandom_range(0, 7) == 0) ? ra : {$urandom, $urandom};
      if ($urandom_range(0, 4) == 0) idle(1);
      else apply(4'($urandom), 2'($urandom), ra, rb);
    end
    idle(2);
    chk_en = 1'b0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule